// File: doc/BRIEF.md
# MSI Vector Message Composer

This block turns an interrupt request from an endpoint function into a single posted memory write that carries a message-signalled interrupt. It reads the function's live capability fields: the message control word, the two halves of the target address and the programmed data word. It then decides whether the request may be honoured and, if so, produces the 64-bit target address and the 16-bit data word for the write.

The block drives a single outbound address window, which it reserves for interrupt traffic. The window is a 256-byte aligned region. The block remembers the last target address it used and asks for the window to be reprogrammed only when a new target address differs from that remembered one. Back-to-back requests to the same target therefore cost no window traffic. Refused requests are reported on an error flag and leave the window state untouched. Packet formation and the link layer sit downstream and are not part of this block.

Top module: `msi_composer`

## Requirements
- R1: A request while message control bit 0 (the enable bit) is 0 is refused: `err` pulses and no write and no window reprogram is issued for it.
- R2: The capable field is message control bits 3:1 and the enabled field is bits 6:4; the effective log2 vector count is the enabled field limited to at most the capable field and at most 5.
- R3: The vector count is 1 shifted left by the effective field; an interrupt number of 0, or one greater than the count, is refused with `err`.
- R4: The write data keeps the programmed data word above its low log2(count) bits and replaces those low bits with the interrupt number minus 1.
- R5: The write target is {address high word, address low word} with bits 1:0 forced to 0.
- R6: When the window is reprogrammed, `win_base` is the target with its low 8 bits cleared; the write address equals that base plus the target's low 8 bits.
- R7: The window is reprogrammed only for an accepted request whose target differs from the remembered target; the first accepted request after reset always reprograms, and no output is asserted out of reset.
- R8: An accepted request produces `wr_valid` two cycles after it is sampled, and a refused one produces `err` at the same point; when a reprogram is needed, `win_load` is asserted in the cycle before `wr_valid`.
- R9: A refused request does not change the remembered target.
- R10: Requests may be presented on consecutive cycles; each one is handled in turn, and a second request to a target that the first has just installed does not reprogram the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_ctrl | input | 16 | Message control word (enable, capable, enabled fields) |
| addr_lo | input | 32 | Low word of the programmed target address |
| addr_hi | input | 32 | High word of the programmed target address |
| msg_data | input | 16 | Programmed message data word |
| req_valid | input | 1 | Interrupt request strobe, one request per cycle |
| req_vec | input | 8 | Requested interrupt number, counted from 1 |
| wr_valid | output | 1 | Write command valid |
| wr_addr | output | 64 | Write target address |
| wr_data | output | 16 | Write data word |
| win_load | output | 1 | Window reprogram strobe |
| win_base | output | 64 | Window base address, 256-byte aligned |
| err | output | 1 | Request refused |

## Verification
The bench builds the block with its default parameters: a 64-bit address, a 16-bit data word, an 8-bit interrupt number, a clamp at 32 vectors and a 256-byte window. With these values, the 3-bit capable and enabled fields can reach 6 and 7. The bench therefore exercises both clamps, including the cap at 5. Interrupt numbers up to 39 reach past the largest count of 32. Random addresses are drawn from a small pool, so cached hits, misses and the reset sentinel all occur many times, with refused requests mixed in.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int MSI_ADDR_W   = 64;
  localparam int MSI_DATA_W   = 16;
  localparam int MSI_CTRL_W   = 16;
  localparam int MSI_VEC_W    = 8;
  localparam int MSI_MAX_LOG2 = 5;
  localparam int MSI_WIN_BITS = 8;

  // message control field positions (decoded by the config space side)
  localparam int CTRL_EN_BIT = 0;
  localparam int CTRL_CAP_LSB = 1;
  localparam int CTRL_ENA_LSB = 4;
  localparam int CTRL_FLD_W = 3;

  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_ERR  = 2'd1,
    RES_SEND = 2'd2
  } msi_res_e;
endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode
  import msi_pkg::*;
#(
  parameter int DATA_W   = MSI_DATA_W,
  parameter int CTRL_W   = MSI_CTRL_W,
  parameter int VEC_W    = MSI_VEC_W,
  parameter int MAX_LOG2 = MSI_MAX_LOG2
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [VEC_W-1:0]  vec_i,
  output logic              ok_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = VEC_W + 1;

  logic [CTRL_FLD_W-1:0] cap_fld;
  logic [CTRL_FLD_W-1:0] ena_fld;
  logic [CTRL_FLD_W-1:0] eff_fld;
  logic [CNT_W-1:0]      vec_cnt;
  logic [VEC_W-1:0]      vec_idx;
  logic [DATA_W-1:0]     low_mask;
  logic [DATA_W-1:0]     idx_ext;

  always_comb begin
    cap_fld = ctrl_i[CTRL_CAP_LSB +: CTRL_FLD_W];
    ena_fld = ctrl_i[CTRL_ENA_LSB +: CTRL_FLD_W];
    eff_fld = (ena_fld > cap_fld) ? cap_fld : ena_fld;
    if (eff_fld > CTRL_FLD_W'(MAX_LOG2)) eff_fld = CTRL_FLD_W'(MAX_LOG2);
    vec_cnt  = CNT_W'(1) << eff_fld;
    vec_idx  = vec_i - VEC_W'(1);
    low_mask = DATA_W'(vec_cnt - CNT_W'(1));
    idx_ext  = DATA_W'(vec_idx);
    ok_o     = ctrl_i[CTRL_EN_BIT] && (vec_i != '0) && ({1'b0, vec_i} <= vec_cnt);
    data_o   = (data_i & ~low_mask) | (idx_ext & low_mask);
  end
endmodule

// File: rtl/msi_win_cache.sv
module msi_win_cache
  import msi_pkg::*;
#(
  parameter int ADDR_W = MSI_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              take_i,
  output logic              miss_o
);
  logic [ADDR_W-1:0] cache_q;
  logic [ADDR_W-1:0] cache_d;
  logic              cache_en;

  // sentinel: bit 0 set, never a legal (word aligned) target
  always_comb begin
    miss_o   = (addr_i != cache_q);
    cache_en = take_i && miss_o;
    cache_d  = addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cache_q <= ADDR_W'(1);
    else if (cache_en) cache_q <= cache_d;
  end
endmodule

// File: rtl/msi_composer.sv
module msi_composer
  import msi_pkg::*;
#(
  parameter int ADDR_W   = MSI_ADDR_W,
  parameter int DATA_W   = MSI_DATA_W,
  parameter int CTRL_W   = MSI_CTRL_W,
  parameter int VEC_W    = MSI_VEC_W,
  parameter int MAX_LOG2 = MSI_MAX_LOG2,
  parameter int WIN_BITS = MSI_WIN_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CTRL_W-1:0]   msg_ctrl,
  input  logic [ADDR_W/2-1:0] addr_lo,
  input  logic [ADDR_W/2-1:0] addr_hi,
  input  logic [DATA_W-1:0]   msg_data,
  input  logic                req_valid,
  input  logic [VEC_W-1:0]    req_vec,
  output logic                wr_valid,
  output logic [ADDR_W-1:0]   wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic                win_load,
  output logic [ADDR_W-1:0]   win_base,
  output logic                err
);
  localparam int ALIGN_BITS = 2;

  logic              rst_n_int;
  logic [ADDR_W-1:0] tgt_addr;
  logic              dec_ok;
  logic [DATA_W-1:0] dec_data;
  logic              take;
  logic              win_miss;

  msi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  msi_vec_decode #(
    .DATA_W   (DATA_W),
    .CTRL_W   (CTRL_W),
    .VEC_W    (VEC_W),
    .MAX_LOG2 (MAX_LOG2)
  ) u_dec (
    .ctrl_i (msg_ctrl),
    .data_i (msg_data),
    .vec_i  (req_vec),
    .ok_o   (dec_ok),
    .data_o (dec_data)
  );

  always_comb begin
    tgt_addr = {addr_hi, addr_lo};
    tgt_addr[ALIGN_BITS-1:0] = '0;
    take = req_valid && dec_ok;
  end

  msi_win_cache #(.ADDR_W(ADDR_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .addr_i (tgt_addr),
    .take_i (take),
    .miss_o (win_miss)
  );

  // stage 1: decision, window reprogram
  msi_res_e          s1_kind_q, s1_kind_d;
  logic              s1_load_q, s1_load_d;
  logic              s1_en;
  logic [ADDR_W-1:0] s1_addr_q;
  logic [DATA_W-1:0] s1_data_q;
  // stage 2: write command / error
  msi_res_e          s2_kind_q;
  logic              s2_en;
  logic [ADDR_W-1:0] s2_addr_q;
  logic [DATA_W-1:0] s2_data_q;

  always_comb begin
    s1_kind_d = RES_NONE;
    if (req_valid) s1_kind_d = dec_ok ? RES_SEND : RES_ERR;
    s1_load_d = take && win_miss;
    s1_en     = take;
    s2_en     = (s1_kind_q == RES_SEND);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      s1_kind_q <= RES_NONE;
      s1_load_q <= 1'b0;
      s2_kind_q <= RES_NONE;
    end else begin
      s1_kind_q <= s1_kind_d;
      s1_load_q <= s1_load_d;
      s2_kind_q <= s1_kind_q;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_en) begin
      s1_addr_q <= tgt_addr;
      s1_data_q <= dec_data;
    end
    if (s2_en) begin
      s2_addr_q <= s1_addr_q;
      s2_data_q <= s1_data_q;
    end
  end

  always_comb begin
    win_load = s1_load_q;
    win_base = {s1_addr_q[ADDR_W-1:WIN_BITS], {WIN_BITS{1'b0}}};
    wr_valid = (s2_kind_q == RES_SEND);
    err      = (s2_kind_q == RES_ERR);
    wr_addr  = {s2_addr_q[ADDR_W-1:WIN_BITS], s2_addr_q[WIN_BITS-1:0]};
    wr_data  = s2_data_q;
  end
endmodule

// File: rtl/msi_composer_chk.sv
module msi_composer_chk #(
  parameter int ADDR_W   = 64,
  parameter int DATA_W   = 16,
  parameter int CTRL_W   = 16,
  parameter int VEC_W    = 8,
  parameter int WIN_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CTRL_W-1:0]   msg_ctrl,
  input logic                req_valid,
  input logic [VEC_W-1:0]    req_vec,
  input logic                wr_valid,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic                win_load,
  input logic [ADDR_W-1:0]   win_base,
  input logic                err
);
  // R1: refusal never comes with a write
  p_err_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && wr_valid));
  // R1: disabled function is refused two cycles later
  p_refuse_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !msg_ctrl[0]) |=> ##1 err);
  // R3: interrupt number zero is refused
  p_zero_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vec == '0) |=> ##1 err);
  // R5: write target is word aligned
  p_addr_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[1:0] == 2'b00));
  // R6: window base is window aligned
  p_base_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_load |-> (win_base[WIN_BITS-1:0] == '0));
  // R7: no reprogram without a request
  p_no_req_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !win_load);
  // R8: reprogram is followed by a write inside that window
  p_load_then_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_load |=> (wr_valid && wr_addr[ADDR_W-1:WIN_BITS] == $past(win_base[ADDR_W-1:WIN_BITS])));
endmodule

bind msi_composer msi_composer_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CTRL_W   (CTRL_W),
  .VEC_W    (VEC_W),
  .WIN_BITS (WIN_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_ctrl  (msg_ctrl),
  .req_valid (req_valid),
  .req_vec   (req_vec),
  .wr_valid  (wr_valid),
  .wr_addr   (wr_addr),
  .win_load  (win_load),
  .win_base  (win_base),
  .err       (err)
);

// File: tb/tb_msi_composer.sv
module tb_msi_composer;
  logic        clk;
  logic        rst_n;
  logic [15:0] msg_ctrl;
  logic [31:0] addr_lo;
  logic [31:0] addr_hi;
  logic [15:0] msg_data;
  logic        req_valid;
  logic [7:0]  req_vec;
  logic        wr_valid;
  logic [63:0] wr_addr;
  logic [15:0] wr_data;
  logic        win_load;
  logic [63:0] win_base;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] m_cache;

  msi_composer dut (
    .clk(clk), .rst_n(rst_n), .msg_ctrl(msg_ctrl), .addr_lo(addr_lo),
    .addr_hi(addr_hi), .msg_data(msg_data), .req_valid(req_valid),
    .req_vec(req_vec), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_load(win_load), .win_base(win_base), .err(err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int m_eff(input logic [15:0] c);
    int cp = int'(c[3:1]);
    int en = int'(c[6:4]);
    int e = (en < cp) ? en : cp;
    if (e > 5) e = 5;
    return e;
  endfunction

  function automatic bit m_ok(input logic [15:0] c, input logic [7:0] v);
    int cnt = 1 << m_eff(c);
    return c[0] && (v != 8'd0) && (int'(v) <= cnt);
  endfunction

  function automatic logic [15:0] m_data(input logic [15:0] c, input logic [15:0] d, input logic [7:0] v);
    int mask = (1 << m_eff(c)) - 1;
    return (d & ~16'(mask)) | 16'((int'(v) - 1) & mask);
  endfunction

  // one isolated request; tag names the requirement of the accept/refuse check
  task automatic do_req(input logic [15:0] c, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [15:0] d, input logic [7:0] v, input string tag);
    bit ok = m_ok(c, v);
    logic [63:0] ea = {hi, lo[31:2], 2'b00};
    logic [15:0] ed = m_data(c, d, v);
    bit el = ok && (ea != m_cache);
    if (el) m_cache = ea;
    @(negedge clk);
    msg_ctrl = c; addr_lo = lo; addr_hi = hi; msg_data = d; req_vec = v; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(win_load == el, "R7 reprogram", 64'(win_load), 64'(el));
    if (el) chk(win_base == {ea[63:8], 8'h00}, "R6 base", win_base, {ea[63:8], 8'h00});
    @(negedge clk);
    chk(wr_valid == ok, {tag, " write"}, 64'(wr_valid), 64'(ok));
    chk(err == !ok, {tag, " err"}, 64'(err), 64'(!ok));
    if (ok) begin
      chk(wr_addr == ea, "R5 R6 addr", wr_addr, ea);
      chk(wr_data == ed, "R4 data", 64'(wr_data), 64'(ed));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    m_cache = 64'h1;
    rst_n = 1'b0; req_valid = 1'b0; msg_ctrl = '0; addr_lo = '0; addr_hi = '0;
    msg_data = '0; req_vec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!wr_valid && !win_load && !err, "R7 reset", {61'd0, wr_valid, win_load, err}, 64'd0);

    // R1: enable clear
    do_req(16'h007E, 32'h1000_0040, 32'h0000_0001, 16'h1234, 8'd1, "R1");
    // R2/R3/R4: cap 3, ena 2 -> 4 vectors
    do_req(16'h0027, 32'h1000_0040, 32'h0000_0001, 16'hABCD, 8'd4, "R3");
    do_req(16'h0027, 32'h1000_0040, 32'h0000_0001, 16'hABCD, 8'd5, "R3");
    do_req(16'h0027, 32'h1000_0040, 32'h0000_0001, 16'hABCD, 8'd0, "R3");
    // R2: clamp to capable (cap 1, ena 4 -> 2 vectors)
    do_req(16'h0043, 32'h1000_0040, 32'h0000_0001, 16'hFFFF, 8'd3, "R2");
    do_req(16'h0043, 32'h1000_0040, 32'h0000_0001, 16'hFFFF, 8'd2, "R2");
    // R2: clamp to 5 (cap 7, ena 7 -> 32 vectors)
    do_req(16'h007F, 32'h1000_0040, 32'h0000_0001, 16'h5A5A, 8'd32, "R2");
    do_req(16'h007F, 32'h1000_0040, 32'h0000_0001, 16'h5A5A, 8'd33, "R2");
    // R5: low address bits forced; new target
    do_req(16'h0001, 32'h2000_01FF, 32'hDEAD_0000, 16'h0042, 8'd1, "R5");
    // R9: refused request to another address, then the cached one again
    do_req(16'h0000, 32'h3000_0000, 32'h0000_0007, 16'h0000, 8'd1, "R9");
    do_req(16'h0001, 32'h2000_01FC, 32'hDEAD_0000, 16'h0042, 8'd1, "R9");

    // R10: back-to-back, new target then same target
    @(negedge clk);
    msg_ctrl = 16'h0013; addr_lo = 32'h4000_0080; addr_hi = 32'h0000_00AA;
    msg_data = 16'h0F00; req_vec = 8'd1; req_valid = 1'b1;
    @(negedge clk);
    req_vec = 8'd2;
    chk(win_load == 1'b1, "R10 first load", 64'(win_load), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(win_load == 1'b0, "R10 second no load", 64'(win_load), 64'd0);
    chk(wr_valid && wr_data == 16'h0F00, "R10 first write", 64'(wr_data), 64'h0F00);
    @(negedge clk);
    chk(wr_valid && wr_data == 16'h0F01, "R10 second write", 64'(wr_data), 64'h0F01);
    m_cache = 64'h0000_00AA_4000_0080;
    @(negedge clk);

    // random mix, R8 latency checked in every call
    for (int i = 0; i < 300; i++) begin
      logic [15:0] c = 16'($urandom());
      logic [31:0] lo;
      logic [31:0] hi;
      c[0] = ($urandom() % 8) != 0;
      lo = 32'h5000_0000 | (32'($urandom() % 4) << 8) | 32'($urandom() % 256);
      hi = ($urandom() % 2) ? 32'h0000_0001 : 32'h0000_0002;
      do_req(c, lo, hi, 16'($urandom()), 8'($urandom() % 40), "R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule